// File: doc/BRIEF.md
# Paired Flash Block Programmer

This controller erases one flash block and then fills it through repeated buffered programs. The flash array is built from two 16-bit command-set devices that share a 32-bit data bus. The low device uses bits 15:0 and the high device uses bits 31:16. Every command is therefore driven into both lanes together, and every status bit is judged in both lanes.

A host pulses `start` with a block-aligned byte address. The controller fetches program words from a local buffer by index and drives a simple synchronous flash bus. When it finishes, it reports one result code together with a one-cycle `done` pulse. Error recovery is built in: after any failure the devices are left in read-array mode. Checking the contents by readback is not part of this block.

Two inputs guard the job. A write-enable gate must be high at the request, otherwise the job is refused. A programmable poll limit bounds every status wait.

Top module: `flash_block_prog`

## Requirements
- R1: Every command byte `c` is driven as `{c,c,c,c}` on `fl_wdata`, so each 16-bit lane carries `{c,c}` (erase = 0x20202020).
- R2: An accepted request writes 0x20 and then 0xD0 to the block base address. It then polls status by reading the base address.
- R3: A status word counts as ready only when bit 7 and bit 23 are both set. A ready erase status with bit 5 or bit 21 set ends the job with code 1.
- R4: Each buffer program starts by writing 0xE8 to the base and reading status. The controller rewrites 0xE8 and reads again for as long as bits 7 and 23 are not both set.
- R5: After the buffer is ready, the controller writes the count 0x000F000F (BUF_WORDS-1 per lane). It then writes BUF_WORDS data words and finally 0xD0. Data word w of buffer b goes to base+64·b+4·w and takes `src_data` at `src_idx` = b·BUF_WORDS+w.
- R6: The controller polls the program status until it is ready, then classifies any error. The classification uses the OR of both lanes, in this priority: bit 3 gives code 2, then bit 1 gives code 3, then bit 4 gives code 4.
- R7: On any error except code 6, the controller writes 0x50 and then 0xFF to the base address before `done`.
- R8: A clean job programs NUM_BUFS buffers at increasing addresses, writes 0xFF to the base, and reports code 0.
- R9: A request made while `wr_allow` is low reports code 6 with `done` in the next cycle. No bus write or read takes place.
- R10: If `poll_limit` consecutive status reads within one wait are all not ready, the job ends with code 5, using the R7 recovery. A ready read arriving exactly at the limit is classified normally.
- R11: `done` is high for exactly one cycle. `busy` is high from the cycle after an accepted request until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, sampled while idle |
| blk_addr | input | ADDR_W | Block-aligned byte base address |
| wr_allow | input | 1 | Write-enable gate |
| poll_limit | input | LIM_W | Maximum not-ready reads per status wait |
| src_idx | output | log2(BUF_WORDS·NUM_BUFS) | Word index into the program buffer |
| src_data | input | 32 | Buffer word at `src_idx`, same cycle |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 32 | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_rdata | input | 32 | Flash read data, valid the cycle after `fl_re` |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result code (0 = success) |

## Verification
The interesting collision is between the poll timeout and the status classification. Both act on the same status read. One test makes the device become ready on exactly the limit-th read while also flagging a program error. The bench expects the error code, not a timeout. Other tests set the ready bit in one lane only, or put error bits in the upper lane only, so a single-lane check fails against the bench's per-cycle model of the bus.

// File: rtl/flp_pkg.sv
// Shared result codes, command bytes and the lane-replication helper.
package flp_pkg;
    typedef enum logic [2:0] {
        E_NONE    = 3'd0,
        E_ERASE   = 3'd1,
        E_VRANGE  = 3'd2,
        E_PROTECT = 3'd3,
        E_PROGRAM = 3'd4,
        E_TIMEOUT = 3'd5,
        E_LOCKED  = 3'd6
    } flp_err_e;

    localparam logic [7:0] C_ERASE   = 8'h20;
    localparam logic [7:0] C_CONFIRM = 8'hD0;
    localparam logic [7:0] C_BUFREQ  = 8'hE8;
    localparam logic [7:0] C_CLRSTAT = 8'h50;
    localparam logic [7:0] C_READARR = 8'hFF;

    // Replicate one command byte into every byte of both 16-bit lanes.
    function automatic logic [31:0] lanes(input logic [7:0] c);
        return {4{c}};
    endfunction
endpackage

// File: rtl/flp_stat_eval.sv
// Status classifier for a pair of 16-bit devices on one 32-bit word.
// Assumes the low device sits in bits 15:0 and the high device in bits 31:16.
module flp_stat_eval
    import flp_pkg::*;
(
    input  logic [31:0] st,
    output logic        ready,
    output logic        erase_bad,
    output flp_err_e    prog_err
);
    logic [15:0] both, any;

    // Combine lanes: readiness needs both, errors need either.
    always_comb begin
        both      = st[15:0] & st[31:16];
        any       = st[15:0] | st[31:16];
        ready     = both[7];
        erase_bad = any[5];
        if (any[3])      prog_err = E_VRANGE;
        else if (any[1]) prog_err = E_PROTECT;
        else if (any[4]) prog_err = E_PROGRAM;
        else             prog_err = E_NONE;
    end
endmodule

// File: rtl/flp_poll_timer.sv
// Counts consecutive not-ready status reads within one wait.
// Assumes clr is raised on every ready read and while the sequencer is idle.
module flp_poll_timer #(
    parameter int LIM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [LIM_W-1:0] limit,
    output logic             expired
);
    logic [LIM_W-1:0] cnt;

    // Advance on every not-ready read, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (tick)     cnt <= cnt + 1'b1;
    end

    // Expire on the read that brings the count up to the limit.
    assign expired = tick && ({1'b0, cnt} + 1'b1 >= {1'b0, limit});
endmodule

// File: rtl/flp_addr_gen.sv
// Buffer and word counters that form the program-buffer index.
// Assumes BUF_WORDS and NUM_BUFS are powers of two and at least two.
module flp_addr_gen #(
    parameter int BUF_WORDS = 16,
    parameter int NUM_BUFS  = 4096,
    localparam int WW    = $clog2(BUF_WORDS),
    localparam int BB    = $clog2(NUM_BUFS),
    localparam int IDX_W = WW + BB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step_word,
    input  logic             step_buf,
    output logic             last_word,
    output logic             last_buf,
    output logic [IDX_W-1:0] idx
);
    logic [WW-1:0] word_q;
    logic [BB-1:0] buf_q;

    // Word counter wraps at the end of each buffer.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)  word_q <= '0;
        else if (step_word) word_q <= last_word ? '0 : word_q + 1'b1;
    end

    // Buffer counter advances after each completed buffer program.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) buf_q <= '0;
        else if (step_buf) buf_q <= buf_q + 1'b1;
    end

    assign last_word = (word_q == WW'(BUF_WORDS - 1));
    assign last_buf  = (buf_q == BB'(NUM_BUFS - 1));
    assign idx       = {buf_q, word_q};

    // R5
    word_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_word && last_word && !clr) |=> (idx[WW-1:0] == '0));
endmodule

// File: rtl/flash_block_prog.sv
// Sequencer for block erase plus buffered programming of a paired-device flash.
// Assumes blk_addr is block aligned and that fl_rdata answers one cycle after fl_re.
module flash_block_prog
    import flp_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int BUF_WORDS = 16,
    parameter int NUM_BUFS  = 4096,
    parameter int LIM_W     = 16
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         start,
    input  logic [ADDR_W-1:0]                            blk_addr,
    input  logic                                         wr_allow,
    input  logic [LIM_W-1:0]                             poll_limit,
    output logic [$clog2(BUF_WORDS)+$clog2(NUM_BUFS)-1:0] src_idx,
    input  logic [31:0]                                  src_data,
    output logic [ADDR_W-1:0]                            fl_addr,
    output logic [31:0]                                  fl_wdata,
    output logic                                         fl_we,
    output logic                                         fl_re,
    input  logic [31:0]                                  fl_rdata,
    output logic                                         busy,
    output logic                                         done,
    output logic [2:0]                                   err_code
);
    localparam int IDX_W = $clog2(BUF_WORDS) + $clog2(NUM_BUFS);
    localparam logic [31:0] COUNT_WORD = {2{16'(BUF_WORDS - 1)}};

    typedef enum logic [3:0] {
        S_IDLE, S_ER_CMD, S_ER_CONF, S_ER_RD, S_ER_CHK,
        S_BF_CMD, S_BF_RD, S_BF_CHK, S_BF_CNT, S_BF_DATA, S_BF_CONF,
        S_PG_RD, S_PG_CHK, S_CLR, S_RDARR, S_DONE
    } st_e;

    st_e             state, nxt;
    flp_err_e        err_q, err_nxt;
    logic [ADDR_W-1:0] base_q;
    logic            ready, erase_bad, expired, last_word, last_buf;
    logic            is_chk, tick, tclr, step_buf;
    flp_err_e        prog_err;

    flp_stat_eval u_eval (.st(fl_rdata), .ready(ready), .erase_bad(erase_bad), .prog_err(prog_err));

    assign is_chk = (state == S_ER_CHK) || (state == S_BF_CHK) || (state == S_PG_CHK);
    assign tick   = is_chk && !ready;
    assign tclr   = (state == S_IDLE) || (is_chk && ready);

    flp_poll_timer #(.LIM_W(LIM_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tclr), .tick(tick), .limit(poll_limit), .expired(expired)
    );

    assign step_buf = (state == S_PG_CHK) && ready && (prog_err == E_NONE) && !last_buf;

    flp_addr_gen #(.BUF_WORDS(BUF_WORDS), .NUM_BUFS(NUM_BUFS)) u_addr (
        .clk(clk), .rst_n(rst_n), .clr(state == S_IDLE), .step_word(state == S_BF_DATA),
        .step_buf(step_buf), .last_word(last_word), .last_buf(last_buf), .idx(src_idx)
    );

    // Next-state and result selection.
    always_comb begin
        nxt     = state;
        err_nxt = err_q;
        unique case (state)
            S_IDLE: if (start) begin
                if (wr_allow) begin nxt = S_ER_CMD; err_nxt = E_NONE;   end
                else          begin nxt = S_DONE;   err_nxt = E_LOCKED; end
            end
            S_ER_CMD:  nxt = S_ER_CONF;
            S_ER_CONF: nxt = S_ER_RD;
            S_ER_RD:   nxt = S_ER_CHK;
            S_ER_CHK:
                if (ready) begin
                    if (erase_bad) begin nxt = S_CLR; err_nxt = E_ERASE; end
                    else nxt = S_BF_CMD;
                end else if (expired) begin nxt = S_CLR; err_nxt = E_TIMEOUT; end
                else nxt = S_ER_RD;
            S_BF_CMD:  nxt = S_BF_RD;
            S_BF_RD:   nxt = S_BF_CHK;
            S_BF_CHK:
                if (ready) nxt = S_BF_CNT;
                else if (expired) begin nxt = S_CLR; err_nxt = E_TIMEOUT; end
                else nxt = S_BF_CMD;
            S_BF_CNT:  nxt = S_BF_DATA;
            S_BF_DATA: if (last_word) nxt = S_BF_CONF;
            S_BF_CONF: nxt = S_PG_RD;
            S_PG_RD:   nxt = S_PG_CHK;
            S_PG_CHK:
                if (ready) begin
                    if (prog_err != E_NONE) begin nxt = S_CLR; err_nxt = prog_err; end
                    else if (last_buf) nxt = S_RDARR;
                    else nxt = S_BF_CMD;
                end else if (expired) begin nxt = S_CLR; err_nxt = E_TIMEOUT; end
                else nxt = S_PG_RD;
            S_CLR:     nxt = S_RDARR;
            S_RDARR:   nxt = S_DONE;
            S_DONE:    nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // State, result and base address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            err_q  <= E_NONE;
            base_q <= '0;
        end else begin
            state <= nxt;
            err_q <= err_nxt;
            if (state == S_IDLE && start) base_q <= blk_addr;
        end
    end

    // Bus drive decoded from the current state.
    always_comb begin
        fl_we    = 1'b0;
        fl_re    = 1'b0;
        fl_addr  = base_q;
        fl_wdata = '0;
        unique case (state)
            S_ER_CMD:  begin fl_we = 1'b1; fl_wdata = lanes(C_ERASE);   end
            S_ER_CONF, S_BF_CONF: begin fl_we = 1'b1; fl_wdata = lanes(C_CONFIRM); end
            S_BF_CMD:  begin fl_we = 1'b1; fl_wdata = lanes(C_BUFREQ);  end
            S_BF_CNT:  begin fl_we = 1'b1; fl_wdata = COUNT_WORD;       end
            S_BF_DATA: begin
                fl_we    = 1'b1;
                fl_wdata = src_data;
                fl_addr  = base_q + ADDR_W'({src_idx, 2'b00});
            end
            S_CLR:     begin fl_we = 1'b1; fl_wdata = lanes(C_CLRSTAT); end
            S_RDARR:   begin fl_we = 1'b1; fl_wdata = lanes(C_READARR); end
            S_ER_RD, S_BF_RD, S_PG_RD: fl_re = 1'b1;
            default: ;
        endcase
    end

    assign busy     = (state != S_IDLE) && (state != S_DONE);
    assign done     = (state == S_DONE);
    assign err_code = err_q;

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && !wr_allow) |=> (done && err_code == E_LOCKED && !fl_we && !fl_re));
    // R2
    erase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ER_CONF) |-> ($past(fl_we) && $past(fl_wdata) == lanes(C_ERASE)));
    // R7
    recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_code != E_NONE && err_code != E_LOCKED) |-> ($past(fl_we) && $past(fl_wdata) == lanes(C_READARR)));
    // R10
    timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> (state == S_CLR && err_q == E_TIMEOUT));
endmodule

// File: tb/flash_block_prog_tb.sv
module flash_block_prog_tb;
    localparam int PERIOD = 10;
    localparam int AW = 24, BW = 16, NB = 4, LW = 16;
    localparam int IW = $clog2(BW) + $clog2(NB);

    logic clk = 0, rst_n = 0, start = 0, wr_allow = 0;
    logic [AW-1:0] blk_addr = '0;
    logic [LW-1:0] poll_limit = 16'd8;
    logic [IW-1:0] src_idx;
    logic [31:0] src_data, fl_wdata, fl_rdata = '0;
    logic [AW-1:0] fl_addr;
    logic fl_we, fl_re, busy, done;
    logic [2:0] err_code;

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pat(input int i);
        return {4'hA, 12'(i), 4'h5, 12'(i)};
    endfunction
    assign src_data = pat(int'(src_idx));

    flash_block_prog #(.ADDR_W(AW), .BUF_WORDS(BW), .NUM_BUFS(NB), .LIM_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_addr(blk_addr), .wr_allow(wr_allow),
        .poll_limit(poll_limit), .src_idx(src_idx), .src_data(src_data), .fl_addr(fl_addr),
        .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata),
        .busy(busy), .done(done), .err_code(err_code));

    int n_chk = 0, n_fail = 0;
    string cur_req = "";

    // Scripted device behaviour.
    int er_wait, bf_wait, pg_wait, err_buf;
    logic [31:0] er_bits, pg_bits;
    int mode = 0, left = 0, bufn = 0;

    always @(posedge clk) begin
        if (fl_we) begin
            if (fl_wdata == 32'h20202020) begin mode = 1; bufn = 0; end
            else if (fl_wdata == 32'hD0D0D0D0 && mode == 1) begin mode = 2; left = er_wait; end
            else if (fl_wdata == 32'hE8E8E8E8 && mode != 3) begin mode = 3; left = bf_wait; end
            else if (fl_wdata == 32'h000F000F && mode == 3) mode = 4;
            else if (fl_wdata == 32'hD0D0D0D0 && mode == 4) begin mode = 5; left = pg_wait; bufn++; end
        end
        if (fl_re) begin
            if (left > 0) begin left--; fl_rdata <= 32'h0000_0080; end
            else if (mode == 2) fl_rdata <= 32'h0080_0080 | er_bits;
            else if (mode == 5 && bufn - 1 == err_buf) fl_rdata <= 32'h0080_0080 | pg_bits;
            else fl_rdata <= 32'h0080_0080;
        end
    end

    // Expected bus transactions: {we, addr, data}.
    logic [56:0] exp_q[$];
    int exp_err;

    task automatic push(input logic we, input logic [AW-1:0] a, input logic [31:0] d);
        exp_q.push_back({we, a, d});
    endtask

    task automatic build(input logic [AW-1:0] base);
        int lim = int'(poll_limit);
        logic [15:0] any;
        exp_q.delete();
        exp_err = 0;
        push(1, base, 32'h20202020);
        push(1, base, 32'hD0D0D0D0);
        if (er_wait >= lim) begin
            for (int k = 0; k < lim; k++) push(0, base, 0);
            exp_err = 5;
        end else begin
            for (int k = 0; k <= er_wait; k++) push(0, base, 0);
            any = er_bits[15:0] | er_bits[31:16];
            if (any[5]) exp_err = 1;
        end
        for (int b = 0; b < NB && exp_err == 0; b++) begin
            if (bf_wait >= lim) begin
                for (int k = 0; k < lim; k++) begin push(1, base, 32'hE8E8E8E8); push(0, base, 0); end
                exp_err = 5;
            end else begin
                for (int k = 0; k <= bf_wait; k++) begin push(1, base, 32'hE8E8E8E8); push(0, base, 0); end
                push(1, base, 32'h000F000F);
                for (int w = 0; w < BW; w++) push(1, base + AW'(64*b + 4*w), pat(b*BW + w));
                push(1, base, 32'hD0D0D0D0);
                if (pg_wait >= lim) begin
                    for (int k = 0; k < lim; k++) push(0, base, 0);
                    exp_err = 5;
                end else begin
                    for (int k = 0; k <= pg_wait; k++) push(0, base, 0);
                    if (b == err_buf) begin
                        any = pg_bits[15:0] | pg_bits[31:16];
                        if (any[3]) exp_err = 2;
                        else if (any[1]) exp_err = 3;
                        else if (any[4]) exp_err = 4;
                    end
                end
            end
        end
        if (exp_err != 0) push(1, base, 32'h50505050);
        push(1, base, 32'hFFFFFFFF);
    endtask

    // Per-cycle comparison of bus activity against the model.
    always @(negedge clk) begin
        if (rst_n && (fl_we || fl_re)) begin
            logic [56:0] e, g;
            g = {fl_we, fl_addr, fl_we ? fl_wdata : 32'h0};
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL %s unexpected bus op actual=%h expected=none", cur_req, g);
            end else begin
                e = exp_q.pop_front();
                if (e != g) begin
                    n_fail++;
                    $display("FAIL %s bus op actual=%h expected=%h", cur_req, g, e);
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic run(input string req, input logic [AW-1:0] base);
        int cyc = 0;
        cur_req = req;
        build(base);
        @(negedge clk);
        blk_addr = base; start = 1;
        @(negedge clk);
        start = 0;
        check({req, " R11 busy"}, {31'b0, busy}, 32'd1);
        while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL %s watchdog actual=no-done expected=done", req);
        end
        check({req, " code"}, {29'b0, err_code}, exp_err);
        check({req, " queue drained"}, exp_q.size(), 0);
        @(negedge clk);
        check({req, " R11 done pulse"}, {31'b0, done}, 32'd0);
    endtask

    task automatic cfg(input int ew, input logic [31:0] eb, input int bw, input int pw,
                       input int eb_i, input logic [31:0] pb, input int lim);
        er_wait = ew; er_bits = eb; bf_wait = bw; pg_wait = pw;
        err_buf = eb_i; pg_bits = pb; poll_limit = LW'(lim);
    endtask

    initial begin
        cfg(0, 0, 0, 0, -1, 0, 8);
        repeat (3) @(negedge clk);
        check("R11 reset busy", {31'b0, busy}, 0);
        check("R11 reset done", {31'b0, done}, 0);
        check("R9 reset bus", {30'b0, fl_we, fl_re}, 0);
        rst_n = 1;
        @(negedge clk);

        // R9: refused request, no bus activity
        cur_req = "R9";
        exp_q.delete();
        wr_allow = 0; blk_addr = 24'h040000; start = 1;
        @(negedge clk); start = 0;
        check("R9 done next cycle", {31'b0, done}, 1);
        check("R9 code locked", {29'b0, err_code}, 6);
        @(negedge clk);
        check("R9 R11 pulse", {31'b0, done}, 0);
        wr_allow = 1;

        // R1 R2 R3 R4 R5 R8: clean job with single-lane-ready waits
        cfg(2, 0, 1, 2, -1, 0, 8);
        run("R1 R2 R3 R4 R5 R8 clean", 24'h080000);
        cfg(0, 0, 0, 0, -1, 0, 8);
        run("R5 R8 clean no-wait", 24'h0C0000);
        // R3: erase error flagged in the upper lane only
        cfg(1, 32'h0020_0000, 0, 0, -1, 0, 8);
        run("R3 R7 erase error", 24'h100000);
        // R6: all three program bits set, range wins
        cfg(0, 0, 0, 1, 1, 32'h0000_001A, 8);
        run("R6 R7 vrange priority", 24'h140000);
        // R6: protect beats program error, upper lane
        cfg(0, 0, 0, 0, 2, 32'h0012_0000, 8);
        run("R6 R7 protect", 24'h180000);
        cfg(0, 0, 0, 0, 3, 32'h0000_0010, 8);
        run("R6 program error", 24'h1C0000);
        // R10: erase never ready within limit
        cfg(10, 0, 0, 0, -1, 0, 4);
        run("R10 R7 erase timeout", 24'h200000);
        // R10: buffer never ready, reissue loop bounded
        cfg(0, 0, 20, 0, -1, 0, 5);
        run("R4 R10 buffer timeout", 24'h240000);
        // R10 boundary: ready on the limit-th read with an error: classify, no timeout
        cfg(0, 0, 0, 3, 0, 32'h0000_0010, 4);
        run("R10 R6 limit boundary", 24'h280000);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule